// File: doc/BRIEF.md
# XOR Swizzle Address Generator

This block turns a logical tile coordinate into a physical byte offset for a banked on-chip scratch memory. Each request carries a row, a column, a row pitch counted in elements, an element size (2 or 4 bytes) and a swizzle selection. The block first forms the plain row-major byte offset. It then optionally flips a few bits of the local part of that offset, using low row bits, inside a 64-byte or 128-byte group. Because only the bits inside a group change, each element stays in the group that a plain layout would give it. The same permutation repeats in every group of a larger tile.

A column-wise walk over a tile, where consecutive lanes read consecutive rows of the same column, normally lands on a single bank. With swizzling on, the same walk spreads across several banks. The result is registered, so it appears one cycle after the request, together with a valid flag.

Top module: `swz_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, before any request is accepted, `out_valid` is 0 and `out_ofs` is 0.
- R2: `out_valid` equals the value `in_valid` had one clock cycle earlier.
- R3: With `mode` 0 or 3 (no swizzle), `out_ofs` equals (row × stride + col) × size one cycle after the request. Size is 4 when `elem_4b` is 1 and 2 when it is 0.
- R4: With `mode` 2 (128-byte groups), `out_ofs` equals the plain offset of R3 with byte-offset bits [6:4] XORed with `row[2:0]`. All other bits are unchanged.
- R5: With `mode` 1 (64-byte groups), `out_ofs` equals the plain offset with bits [5:4] XORed with `row[1:0]`. All other bits are unchanged.
- R6: Within one group (128 bytes in mode 2, 64 bytes in mode 1), distinct plain offsets map to distinct physical offsets. Every result keeps the group base of its plain offset.
- R7: While `in_valid` is 0, `out_ofs` holds its previous value whatever the other inputs do.
- R8: A 32-lane column walk (lane l at row l, column 0, stride 32, 4-byte elements), with bank = (offset / 4) mod 32, touches exactly one bank with no swizzle and eight distinct banks with mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| row | input | ROW_W | Logical row index |
| col | input | COL_W | Logical column index, in elements |
| stride | input | STRIDE_W | Row pitch, in elements |
| elem_4b | input | 1 | 1: 4-byte elements, 0: 2-byte elements |
| mode | input | 2 | 0 none, 1 64-byte groups, 2 128-byte groups, 3 none |
| out_valid | output | 1 | Result valid |
| out_ofs | output | OFS_W | Physical byte offset |

## Verification
The mapping is driven with row sweeps of full 128-byte and 64-byte groups in both element sizes. These sweeps show whether the permutation stays one-to-one and keeps each group base. A column walk down 32 rows compares bank spread with and without swizzling, which separates a working XOR from one that is absent or applied to the wrong bits. Scattered coordinates with odd strides and the unused mode code 3 check the plain address arithmetic. A stretch of idle cycles with changing inputs checks that the output holds.

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int STRIDE_W = 12,
  parameter int OFS_W    = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ROW_W-1:0]    row,
  input  logic [COL_W-1:0]    col,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                elem_4b,
  input  logic [1:0]          mode,
  output logic                out_valid,
  output logic [OFS_W-1:0]    out_ofs
);
  localparam logic [1:0] SEL64  = 2'd1;
  localparam logic [1:0] SEL128 = 2'd2;

  logic [OFS_W-1:0] row_x, col_x, str_x, idx, lin, flip;

  assign row_x = {{(OFS_W-ROW_W){1'b0}}, row};
  assign col_x = {{(OFS_W-COL_W){1'b0}}, col};
  assign str_x = {{(OFS_W-STRIDE_W){1'b0}}, stride};
  assign idx   = row_x * str_x + col_x;
  assign lin   = elem_4b ? (idx << 2) : (idx << 1);

  always_comb begin
    flip = '0;
    case (mode)
      SEL128:  flip[6:4] = row[2:0];
      SEL64:   flip[5:4] = row[1:0];
      default: flip = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ofs   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_ofs <= lin ^ flip;
    end
  end
endmodule

// File: rtl/swz_addr_gen_chk.sv
module swz_addr_gen_chk #(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int STRIDE_W = 12,
  parameter int OFS_W    = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [ROW_W-1:0]    row,
  input logic [COL_W-1:0]    col,
  input logic [STRIDE_W-1:0] stride,
  input logic                elem_4b,
  input logic [1:0]          mode,
  input logic                out_valid,
  input logic [OFS_W-1:0]    out_ofs
);
  logic [OFS_W-1:0] ref_ofs;
  logic [OFS_W-1:0] keep128, keep64;
  assign ref_ofs = (OFS_W'(row) * OFS_W'(stride) + OFS_W'(col)) * (elem_4b ? OFS_W'(4) : OFS_W'(2));
  assign keep128 = ~(OFS_W'(7) << 4);
  assign keep64  = ~(OFS_W'(3) << 4);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R3
  plain_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 2'd0 || mode == 2'd3)) |=> out_ofs == $past(ref_ofs));
  // R4
  swz128_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2) |=> ((out_ofs ^ $past(ref_ofs)) & keep128) == '0);
  // R5
  swz64_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |=> ((out_ofs ^ $past(ref_ofs)) & keep64) == '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ofs));
endmodule

bind swz_addr_gen swz_addr_gen_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .STRIDE_W(STRIDE_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/sim_swz_addr_gen.sv
module sim_swz_addr_gen;
  localparam int ROW_W = 10, COL_W = 10, STRIDE_W = 12, OFS_W = 24;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, elem_4b = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic [COL_W-1:0] col = '0;
  logic [STRIDE_W-1:0] stride = '0;
  logic [1:0] mode = '0;
  logic out_valid;
  logic [OFS_W-1:0] out_ofs;

  int checks = 0, errors = 0;
  logic [OFS_W-1:0] exp_q[$];
  string tag_q[$];
  logic [OFS_W-1:0] obs[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  swz_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .STRIDE_W(STRIDE_W), .OFS_W(OFS_W)) u0 (.*);

  function automatic logic [OFS_W-1:0] model(int r, int c, int s, bit e4, int m);
    logic [OFS_W-1:0] v;
    v = OFS_W'((r * s + c) * (e4 ? 4 : 2));
    if (m == 2) v[6:4] = v[6:4] ^ 3'(r);
    if (m == 1) v[5:4] = v[5:4] ^ 2'(r);
    return v;
  endfunction

  task automatic check(string tag, logic [OFS_W-1:0] act, logic [OFS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int r, int c, int s, bit e4, int m, string tag);
    @(negedge clk);
    in_valid = 1'b1; row = ROW_W'(r); col = COL_W'(c);
    stride = STRIDE_W'(s); elem_4b = e4; mode = 2'(m);
    exp_q.push_back(model(r, c, s, e4, m));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected valid", 1, 0);
      else check(tag_q.pop_front(), out_ofs, exp_q.pop_front());
      obs.push_back(out_ofs);
    end
  end

  task automatic group_test(bit e4, int m, int nrows, string tag);
    int gb = (m == 2) ? 7 : 6;
    int n  = (m == 2) ? (e4 ? 32 : 64) : (e4 ? 16 : 32);
    for (int r = 0; r < nrows; r++) begin
      obs.delete();
      for (int c = 0; c < n; c++) drive(r, c, n, e4, m, tag);
      idle(2);
      begin
        int dup = 0, off = 0;
        for (int i = 0; i < obs.size(); i++) begin
          if ((obs[i] >> gb) != OFS_W'(r)) off++;
          for (int j = i + 1; j < obs.size(); j++) if (obs[i] == obs[j]) dup++;
        end
        check({tag, " count"}, OFS_W'(obs.size()), OFS_W'(n));
        check({tag, " duplicates"}, OFS_W'(dup), 0);
        check({tag, " group base"}, OFS_W'(off), 0);
      end
    end
  endtask

  task automatic bank_walk(int m, int expect_banks);
    logic [31:0] hit = '0;
    obs.delete();
    for (int l = 0; l < 32; l++) drive(l, 0, 32, 1'b1, m, "R8 walk");
    idle(2);
    foreach (obs[i]) hit[obs[i][6:2]] = 1'b1;
    check("R8 distinct banks", OFS_W'($countones(hit)), OFS_W'(expect_banks));
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [OFS_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", OFS_W'(out_valid), 0);
    check("R1 offset in reset", out_ofs, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 valid after reset", OFS_W'(out_valid), 0);
    check("R1 offset after reset", out_ofs, 0);

    drive(3, 5, 37, 1'b1, 0, "R3 plain 4B");
    drive(7, 1, 19, 1'b0, 0, "R3 plain 2B");
    drive(100, 33, 250, 1'b1, 3, "R3 code 3");
    drive(13, 9, 64, 1'b1, 2, "R4 swizzle 128B");
    drive(13, 9, 64, 1'b0, 2, "R4 swizzle 128B 2B");
    drive(21, 40, 96, 1'b1, 2, "R4 later atom");
    drive(6, 3, 32, 1'b0, 1, "R5 swizzle 64B");
    drive(15, 11, 48, 1'b1, 1, "R5 swizzle 64B 4B");
    idle(2);
    check("R2 valid drops", OFS_W'(out_valid), 0);

    held = out_ofs;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      row = ROW_W'(i + 50); col = COL_W'(i * 3); mode = 2'd2;
      check("R7 hold", out_ofs, held);
    end

    group_test(1'b1, 2, 8, "R6 128B 4B");
    group_test(1'b0, 2, 2, "R6 128B 2B");
    group_test(1'b0, 1, 4, "R6 64B 2B");
    group_test(1'b1, 1, 2, "R6 64B 4B");

    bank_walk(0, 1);
    bank_walk(2, 8);

    check("R2 queue drained", OFS_W'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule